// File: doc/BRIEF.md
# Extended I/O interrupt router

This block collects a vector of level-sensitive device interrupt inputs and steers each one to one of a few CPU cores. Each core has a small set of parent interrupt lines. Routing uses two byte tables. Each group of 32 consecutive sources shares one byte that selects the parent line. Each source has its own byte that selects the target core. A mode bit in the global status word decides how each table's bytes are read: as a one-hot value (lowest set bit wins) or as a binary index.

A source that is enabled and pending is recorded in the in-service vector of its target core. A parent line is the OR of every in-service source that routes to it. Software clears in-service bits with write-1-to-clear accesses. Changing the enable mask or the core table while a source is pending moves or withdraws that source at once, so parent lines always match the current routing.

Every register sits behind a 64-bit register bus that accepts byte, half, word and doubleword accesses. A core-ID field travels with each access and selects which core's in-service vector is read or cleared. Each access returns a response one cycle later.

Top module: `eio_router`

## Requirements
- R1: The line map at byte offset 0x10 holds one byte per group of 32 sources; source n uses byte n/32. With status bit 2 clear, a byte selects the line at the position of its lowest set bit. With status bit 2 set, the byte is a binary line number. In both modes a result of 4 or more, and an all-zero one-hot byte, selects line 0.
- R2: The core map at byte offset 0xC0 + n holds one byte for source n. With status bit 1 clear, the byte selects the core at the position of its lowest set bit. With status bit 1 set, the byte is a binary core number. In both modes a result of 4 or more, and an all-zero one-hot byte, selects core 0.
- R3: A rising input sets the source's bit in the raw vector (read-only, offset 0x80) in every case. It also sets the source's in-service bit at its target core, but only if its enable bit (offset 0x40, bit n) is 1. A falling input clears both.
- R4: irq_o[c*4+l] is the OR of the in-service sources of core c that are routed to line l. It rises when the first such source becomes active and falls only when the last one clears. It changes one cycle after the input or bus write that causes it.
- R5: Offset 0xA0 reads the in-service bits of the core named by core_id_i. A write there is write-1-to-clear on that core only. Clearing a set bit removes that source from its parent line.
- R6: A write that changes an enable bit from 0 to 1 while the raw bit is set raises that source. A write that changes it from 1 to 0 while the raw bit is set lowers it.
- R7: Rewriting a core-map byte of a pending source to a different decoded core clears the source at the old core, and sets it at the new core if it is enabled. If the decoded core stays the same, nothing changes.
- R8: A write changes only the bytes it addresses: a size mask (size 0/1/2/3 = 1/2/4/8 bytes) shifted left by addr[2:0] bytes. An address not aligned to the access size gives an error and changes nothing.
- R9: The status word at offset 0x00 (bit 0 enable, bit 1 core binary mode, bit 2 line binary mode) stores the written value ANDed with FEATURE_MASK, which reads at 0x08. Writing 0x08 is an error. A nonzero status write while bit 0 is set is refused with an error.
- R10: A read of an unmapped offset returns zero with an error. A write to an unmapped offset or to the raw vector is an error and changes nothing.
- R11: After reset every register, the status word and all parent lines are zero.
- R12: rsp_valid_o is high exactly one cycle after each request. Read data is the addressed doubleword shifted right by addr[2:0] bytes and masked to the access size. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level-sensitive device interrupt inputs |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| wdata_i | input | 64 | Write data, right-justified |
| core_id_i | input | CW | Core issuing the access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Access error |
| rdata_o | output | 64 | Read data |
| irq_o | output | NCORES*NLINES | Parent lines, index core*NLINES+line |

## Verification
The bench targets the cases where aggregation and routing can drift apart. It drops one of two sources that share a line, where a design that deasserts per source would release the line too early. It re-enables and disables a pending source, where a design acting only on input edges would leave the line stale. It moves a pending source to another core, and rewrites its core byte to a different value that decodes to the same core; a wrong design would strand the bit at the old core or drop it. It also clears in-service bits from the wrong core, where a design ignoring the core ID would clear the line. Finally it drives out-of-range decode bytes, a refused status write while enabled, partial writes and a misaligned write, where a wrong design would misroute a source or corrupt neighbouring bytes.

// File: rtl/eio_pkg.sv
package eio_pkg;

    localparam int STATUS_W    = 8;
    localparam int ST_EN       = 0;
    localparam int ST_CORE_BIN = 1;
    localparam int ST_LINE_BIN = 2;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_STATUS,
        RG_FEATURE,
        RG_LMAP,
        RG_NODE,
        RG_ENABLE,
        RG_BOUNCE,
        RG_RAW,
        RG_ISR,
        RG_CMAP
    } eio_region_e;

    // Decode one routing byte: binary index, or lowest set bit; out of range gives 0.
    function automatic int unsigned eio_pick(input logic [7:0] b, input logic binary,
                                             input int unsigned limit);
        int unsigned r;
        r = 8;
        if (binary) begin
            r = {24'd0, b};
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (b[7-i]) r = 7 - i;
            end
        end
        if (r >= limit) r = 0;
        return r;
    endfunction

endpackage

// File: rtl/eio_regbus.sv
module eio_regbus
    import eio_pkg::*;
#(
    parameter int NSRC    = 256,
    parameter int NODE_DW = 2,
    parameter int AW      = 9,
    localparam int IW     = AW - 3
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    size_i,
    input  logic [63:0]   wdata_i,
    output eio_region_e   region_o,
    output logic [IW-1:0] idx_o,
    output logic [5:0]    shift_o,
    output logic [63:0]   size_mask_o,
    output logic [63:0]   lane_mask_o,
    output logic [63:0]   lane_data_o,
    output logic          misaligned_o
);
    localparam int SW     = NSRC / 64;
    localparam int B_NODE = 4;
    localparam int B_EN   = 8;
    localparam int B_BO   = B_EN + SW;
    localparam int B_RAW  = B_BO + SW;
    localparam int B_ISR  = B_RAW + SW;
    localparam int B_CM   = B_ISR + SW;
    localparam int B_END  = B_CM + NSRC / 8;

    int dn;

    always_comb begin
        unique case (size_i)
            2'd0:    size_mask_o = 64'h0000_0000_0000_00FF;
            2'd1:    size_mask_o = 64'h0000_0000_0000_FFFF;
            2'd2:    size_mask_o = 64'h0000_0000_FFFF_FFFF;
            default: size_mask_o = '1;
        endcase
        unique case (size_i)
            2'd0:    misaligned_o = 1'b0;
            2'd1:    misaligned_o = addr_i[0];
            2'd2:    misaligned_o = |addr_i[1:0];
            default: misaligned_o = |addr_i[2:0];
        endcase
        shift_o     = {addr_i[2:0], 3'b000};
        lane_mask_o = size_mask_o << shift_o;
        lane_data_o = (wdata_i & size_mask_o) << shift_o;

        dn       = int'(addr_i[AW-1:3]);
        region_o = RG_NONE;
        idx_o    = '0;
        if (dn == 0) begin
            region_o = RG_STATUS;
        end else if (dn == 1) begin
            region_o = RG_FEATURE;
        end else if (dn == 2) begin
            region_o = RG_LMAP;
        end else if (dn >= B_NODE && dn < B_NODE + NODE_DW) begin
            region_o = RG_NODE;
            idx_o    = IW'(dn - B_NODE);
        end else if (dn >= B_EN && dn < B_BO) begin
            region_o = RG_ENABLE;
            idx_o    = IW'(dn - B_EN);
        end else if (dn >= B_BO && dn < B_RAW) begin
            region_o = RG_BOUNCE;
            idx_o    = IW'(dn - B_BO);
        end else if (dn >= B_RAW && dn < B_ISR) begin
            region_o = RG_RAW;
            idx_o    = IW'(dn - B_RAW);
        end else if (dn >= B_ISR && dn < B_CM) begin
            region_o = RG_ISR;
            idx_o    = IW'(dn - B_ISR);
        end else if (dn >= B_CM && dn < B_END) begin
            region_o = RG_CMAP;
            idx_o    = IW'(dn - B_CM);
        end
    end

endmodule

// File: rtl/eio_line_aggregate.sv
module eio_line_aggregate
    import eio_pkg::*;
#(
    parameter int NSRC   = 256,
    parameter int NCORES = 4,
    parameter int NLINES = 4,
    parameter int GRP    = 32,
    localparam int NGRP  = NSRC / GRP,
    localparam int LW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic [NCORES-1:0][NSRC-1:0] isr_i,
    input  logic [NGRP-1:0][7:0]        lmap_i,
    input  logic                        line_bin_i,
    output logic [NCORES*NLINES-1:0]    irq_o
);
    logic [NGRP-1:0][LW-1:0]     grp_line;
    logic [NLINES-1:0][NSRC-1:0] sel;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_line[g] = LW'(eio_pick(lmap_i[g], line_bin_i, NLINES));
    end

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign sel[l][s] = (grp_line[s/GRP] == LW'(l));
        end
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        for (genvar l = 0; l < NLINES; l++) begin : g_out
            assign irq_o[c*NLINES+l] = |(isr_i[c] & sel[l]);
        end
    end

endmodule

// File: rtl/eio_router.sv
module eio_router
    import eio_pkg::*;
#(
    parameter int             NSRC         = 256,
    parameter int             NCORES       = 4,
    parameter int             NLINES       = 4,
    parameter int             GRP          = 32,
    parameter int             NODE_DW      = 2,
    parameter logic [STATUS_W-1:0] FEATURE_MASK = 8'h07,
    localparam int            AW           = $clog2((8 + 4*(NSRC/64) + NSRC/8) * 8),
    localparam int            CW           = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NSRC-1:0]          src_i,
    input  logic                     req_i,
    input  logic                     we_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [1:0]               size_i,
    input  logic [63:0]              wdata_i,
    input  logic [CW-1:0]            core_id_i,
    output logic                     rsp_valid_o,
    output logic                     rsp_err_o,
    output logic [63:0]              rdata_o,
    output logic [NCORES*NLINES-1:0] irq_o
);
    localparam int NGRP = NSRC / GRP;
    localparam int IW   = AW - 3;

    typedef struct packed {
        logic [NSRC-1:0]             raw;
        logic [NSRC-1:0]             en;
        logic [NSRC-1:0]             bounce;
        logic [NCORES-1:0][NSRC-1:0] isr;
        logic [NSRC-1:0][7:0]        cmap;
        logic [NGRP-1:0][7:0]        lmap;
        logic [NODE_DW-1:0][63:0]    node;
        logic [STATUS_W-1:0]         status;
        logic                        rsp_valid;
        logic                        rsp_err;
        logic [63:0]                 rsp_data;
    } state_t;

    state_t q, d;

    eio_region_e   region;
    logic [IW-1:0] idx;
    logic [5:0]    shift;
    logic [63:0]   size_mask, lane_mask, lane_data;
    logic          misaligned;

    eio_regbus #(
        .NSRC(NSRC), .NODE_DW(NODE_DW), .AW(AW)
    ) u_regbus (
        .addr_i      (addr_i),
        .size_i      (size_i),
        .wdata_i     (wdata_i),
        .region_o    (region),
        .idx_o       (idx),
        .shift_o     (shift),
        .size_mask_o (size_mask),
        .lane_mask_o (lane_mask),
        .lane_data_o (lane_data),
        .misaligned_o(misaligned)
    );

    // Current target core of every source, decoded from the stored map.
    logic [NSRC-1:0][CW-1:0] tgt_q;
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            tgt_q[s] = CW'(eio_pick(q.cmap[s], q.status[ST_CORE_BIN], NCORES));
        end
    end

    function automatic logic [63:0] blend(input logic [63:0] old_v, input logic [63:0] m,
                                          input logic [63:0] v);
        return (old_v & ~m) | v;
    endfunction

    logic [63:0]   rd_word, new_word;
    logic          acc_err;
    logic [CW-1:0] old_t, new_t, edge_t;
    int            base;

    always_comb begin
        d           = q;
        d.raw       = src_i;
        d.rsp_valid = req_i;
        d.rsp_err   = 1'b0;
        d.rsp_data  = '0;
        rd_word     = '0;
        new_word    = '0;
        acc_err     = 1'b0;
        old_t       = '0;
        new_t       = '0;
        edge_t      = '0;
        base        = int'(idx);

        // Register access; pending state is taken from before this cycle.
        if (req_i) begin
            if (misaligned) begin
                acc_err = 1'b1;
            end else begin
                unique case (region)
                    RG_STATUS: begin
                        rd_word  = 64'(q.status);
                        new_word = blend(rd_word, lane_mask, lane_data);
                        if (we_i) begin
                            if (q.status[ST_EN] && (new_word[STATUS_W-1:0] != '0)) acc_err = 1'b1;
                            else d.status = new_word[STATUS_W-1:0] & FEATURE_MASK;
                        end
                    end
                    RG_FEATURE: begin
                        rd_word = 64'(FEATURE_MASK);
                        if (we_i) acc_err = 1'b1;
                    end
                    RG_LMAP: begin
                        rd_word  = 64'(q.lmap);
                        new_word = blend(rd_word, lane_mask, lane_data);
                        if (we_i) d.lmap = new_word[NGRP*8-1:0];
                    end
                    RG_NODE: begin
                        rd_word = q.node[base];
                        if (we_i) d.node[base] = blend(rd_word, lane_mask, lane_data);
                    end
                    RG_ENABLE: begin
                        rd_word  = q.en[base*64 +: 64];
                        new_word = blend(rd_word, lane_mask, lane_data);
                        if (we_i) begin
                            d.en[base*64 +: 64] = new_word;
                            for (int b = 0; b < 64; b++) begin
                                if (q.raw[base*64+b] && new_word[b] && !rd_word[b])
                                    d.isr[tgt_q[base*64+b]][base*64+b] = 1'b1;
                                if (q.raw[base*64+b] && !new_word[b] && rd_word[b])
                                    d.isr[tgt_q[base*64+b]][base*64+b] = 1'b0;
                            end
                        end
                    end
                    RG_BOUNCE: begin
                        rd_word = q.bounce[base*64 +: 64];
                        if (we_i) d.bounce[base*64 +: 64] = blend(rd_word, lane_mask, lane_data);
                    end
                    RG_RAW: begin
                        rd_word = q.raw[base*64 +: 64];
                        if (we_i) acc_err = 1'b1;
                    end
                    RG_ISR: begin
                        rd_word = q.isr[core_id_i][base*64 +: 64];
                        if (we_i) d.isr[core_id_i][base*64 +: 64] = rd_word & ~lane_data;
                    end
                    RG_CMAP: begin
                        rd_word  = q.cmap[base*8 +: 8];
                        new_word = blend(rd_word, lane_mask, lane_data);
                        if (we_i) begin
                            for (int b = 0; b < 8; b++) begin
                                old_t = tgt_q[base*8+b];
                                new_t = CW'(eio_pick(new_word[b*8 +: 8], q.status[ST_CORE_BIN], NCORES));
                                d.cmap[base*8+b] = new_word[b*8 +: 8];
                                if ((new_t != old_t) && q.raw[base*8+b]) begin
                                    d.isr[old_t][base*8+b] = 1'b0;
                                    if (q.en[base*8+b]) d.isr[new_t][base*8+b] = 1'b1;
                                end
                            end
                        end
                    end
                    default: acc_err = 1'b1;
                endcase
            end
            d.rsp_err = acc_err;
            if (!we_i && !acc_err) d.rsp_data = (rd_word >> shift) & size_mask;
        end

        // Input edges, judged against the enable mask and routing after the write.
        for (int s = 0; s < NSRC; s++) begin
            edge_t = CW'(eio_pick(d.cmap[s], d.status[ST_CORE_BIN], NCORES));
            if (src_i[s] && !q.raw[s] && d.en[s]) d.isr[edge_t][s] = 1'b1;
            if (!src_i[s] && q.raw[s])            d.isr[edge_t][s] = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    eio_line_aggregate #(
        .NSRC(NSRC), .NCORES(NCORES), .NLINES(NLINES), .GRP(GRP)
    ) u_agg (
        .isr_i     (q.isr),
        .lmap_i    (q.lmap),
        .line_bin_i(q.status[ST_LINE_BIN]),
        .irq_o     (irq_o)
    );

    assign rsp_valid_o = q.rsp_valid;
    assign rsp_err_o   = q.rsp_err;
    assign rdata_o     = q.rsp_data;

endmodule

// File: rtl/eio_router_chk.sv
module eio_router_chk
    import eio_pkg::*;
#(
    parameter int NSRC   = 256,
    parameter int NCORES = 4,
    parameter int NLINES = 4,
    parameter int AW     = 9
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        req_i,
    input logic                        we_i,
    input logic [AW-1:0]               addr_i,
    input logic [1:0]                  size_i,
    input logic [63:0]                 wdata_i,
    input logic                        rsp_valid_o,
    input logic                        rsp_err_o,
    input logic [NCORES*NLINES-1:0]    irq_o,
    input logic [NCORES-1:0][NSRC-1:0] isr_i,
    input logic [STATUS_W-1:0]         status_i
);
    logic bad_align;
    always_comb begin
        case (size_i)
            2'd0:    bad_align = 1'b0;
            2'd1:    bad_align = addr_i[0];
            2'd2:    bad_align = addr_i[1] | addr_i[0];
            default: bad_align = addr_i[2] | addr_i[1] | addr_i[0];
        endcase
    end

    // R12: one response per request, one cycle later
    p_rsp_follows_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> rsp_valid_o);
    p_no_rsp_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !rsp_valid_o);

    // R8: misaligned access reports an error
    p_misalign_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && bad_align) |=> rsp_err_o);

    // R9: status locked while enabled
    p_status_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i && addr_i == '0 && size_i == 2'd3 && status_i[ST_EN] &&
         wdata_i[STATUS_W-1:0] != '0) |=> (rsp_err_o && $stable(status_i)));

    // R11: parent lines are quiet during reset
    p_reset_quiet_r11: assert property (@(posedge clk_i)
        !rst_ni |=> irq_o == '0);

    // R4: a core's parent line only with an in-service source on that core
    for (genvar c = 0; c < NCORES; c++) begin : g_core
        p_line_needs_isr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (|irq_o[c*NLINES +: NLINES]) |-> (|isr_i[c]));
    end

endmodule

bind eio_router eio_router_chk #(
    .NSRC(NSRC), .NCORES(NCORES), .NLINES(NLINES), .AW(AW)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .size_i     (size_i),
    .wdata_i    (wdata_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_err_o  (rsp_err_o),
    .irq_o      (irq_o),
    .isr_i      (q.isr),
    .status_i   (q.status)
);

// File: tb/tb_eio_router.sv
module tb_eio_router;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] src = '0;
    logic         req = 1'b0;
    logic         we = 1'b0;
    logic [8:0]   addr = '0;
    logic [1:0]   size = '0;
    logic [63:0]  wdata = '0;
    logic [1:0]   core = '0;
    logic         rsp_valid, rsp_err;
    logic [63:0]  rdata;
    logic [15:0]  irq;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    eio_router dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
        .addr_i(addr), .size_i(size), .wdata_i(wdata), .core_id_i(core),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rdata_o(rdata), .irq_o(irq)
    );

    localparam logic [8:0] A_ST = 9'h000, A_EN = 9'h040, A_RAW = 9'h080;
    localparam logic [8:0] A_ISR = 9'h0A0, A_CM = 9'h0C0;

    // {we, addr, size, wdata, expected data, expected error}
    localparam logic [140:0] VECS [0:13] = '{
        {1'b0, 9'h000, 2'd3, 64'h0, 64'h0, 1'b0},                                 // R11 status zero
        {1'b0, 9'h008, 2'd3, 64'h0, 64'h7, 1'b0},                                 // R9 feature mask
        {1'b1, 9'h010, 2'd3, 64'h0C06_1000_0804_0201, 64'h0, 1'b0},               // R1 line map
        {1'b0, 9'h010, 2'd3, 64'h0, 64'h0C06_1000_0804_0201, 1'b0},
        {1'b1, 9'h013, 2'd0, 64'hFF, 64'h0, 1'b0},                                // R8 byte write
        {1'b0, 9'h010, 2'd3, 64'h0, 64'h0C06_1000_FF04_0201, 1'b0},               // R8
        {1'b1, 9'h013, 2'd0, 64'h08, 64'h0, 1'b0},
        {1'b0, 9'h012, 2'd1, 64'h0, 64'h0804, 1'b0},                              // R12 half read
        {1'b1, 9'h011, 2'd1, 64'hFFFF, 64'h0, 1'b1},                              // R8 misaligned
        {1'b0, 9'h010, 2'd3, 64'h0, 64'h0C06_1000_0804_0201, 1'b0},               // R8 unchanged
        {1'b0, 9'h018, 2'd3, 64'h0, 64'h0, 1'b1},                                 // R10 unmapped
        {1'b1, 9'h080, 2'd3, 64'h1, 64'h0, 1'b1},                                 // R10 raw ro
        {1'b0, 9'h080, 2'd3, 64'h0, 64'h0, 1'b0},                                 // R10 raw intact
        {1'b1, 9'h008, 2'd3, 64'h0, 64'h0, 1'b1}                                  // R9 feature ro
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [8:0] a, input logic [1:0] sz,
                       input logic [63:0] wd, input logic [1:0] c,
                       output logic [63:0] rd, output logic er);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; size = sz; wdata = wd; core = c;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        rd = rdata; er = rsp_err;
    endtask

    task automatic set_src(input int n, input logic v);
        @(negedge clk);
        src[n] = v;
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] rd;
        logic        er;
        repeat (3) @(negedge clk);
        chk("R11 irq in reset", 64'(irq), 64'h0);
        chk("R11 no response in reset", 64'(rsp_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 irq after reset", 64'(irq), 64'h0);

        for (int i = 0; i < 14; i++) begin
            logic [140:0] v;
            v = VECS[i];
            bus(v[140], v[139:131], v[130:129], v[128:65], 2'd0, rd, er);
            chk($sformatf("R8/R9/R10/R11/R12 vector %0d data", i), rd, v[64:1]);
            chk($sformatf("R8/R9/R10/R12 vector %0d err", i), 64'(er), 64'(v[0]));
        end

        // R3: disabled source is recorded raw only
        set_src(0, 1'b1);
        chk("R3 disabled no irq", 64'(irq), 64'h0);
        bus(1'b0, A_RAW, 2'd3, 0, 2'd0, rd, er);
        chk("R3 raw set", rd, 64'h1);
        bus(1'b0, A_ISR, 2'd3, 0, 2'd0, rd, er);
        chk("R3 no in-service while disabled", rd, 64'h0);
        // R6: enable while pending raises
        bus(1'b1, A_EN, 2'd3, 64'h1, 2'd0, rd, er);
        chk("R6 enable raises", 64'(irq), 64'h1);
        // R3/R4: second source on same line
        bus(1'b1, A_EN, 2'd3, 64'h3, 2'd0, rd, er);
        set_src(1, 1'b1);
        chk("R4 shared line", 64'(irq), 64'h1);
        bus(1'b0, A_ISR, 2'd3, 0, 2'd0, rd, er);
        chk("R3 in-service both", rd, 64'h3);
        set_src(0, 1'b0);
        chk("R4 line held by last source", 64'(irq), 64'h1);
        set_src(1, 1'b0);
        chk("R4 line drops with last", 64'(irq), 64'h0);
        // R5: write-1-to-clear on the accessing core only
        set_src(1, 1'b1);
        chk("R3 rise enabled", 64'(irq), 64'h1);
        bus(1'b1, A_ISR, 2'd3, 64'h2, 2'd1, rd, er);
        chk("R5 other core clear ignored", 64'(irq), 64'h1);
        bus(1'b0, A_ISR, 2'd3, 0, 2'd1, rd, er);
        chk("R5 core1 view empty", rd, 64'h0);
        bus(1'b1, A_ISR, 2'd3, 64'h2, 2'd0, rd, er);
        chk("R5 clear drops line", 64'(irq), 64'h0);
        bus(1'b0, A_ISR, 2'd3, 0, 2'd0, rd, er);
        chk("R5 core0 cleared", rd, 64'h0);
        bus(1'b0, A_RAW, 2'd3, 0, 2'd0, rd, er);
        chk("R5 raw kept", rd, 64'h2);
        // R6: disable/enable while pending
        bus(1'b1, A_EN, 2'd3, 64'h1, 2'd0, rd, er);
        chk("R6 disable when not in service", 64'(irq), 64'h0);
        bus(1'b1, A_EN, 2'd3, 64'h3, 2'd0, rd, er);
        chk("R6 re-enable raises", 64'(irq), 64'h1);
        bus(1'b1, A_EN, 2'd3, 64'h1, 2'd0, rd, er);
        chk("R6 disable lowers", 64'(irq), 64'h0);
        bus(1'b1, A_EN, 2'd3, 64'h3, 2'd0, rd, er);
        chk("R6 enable again", 64'(irq), 64'h1);
        // R7: move pending source to core 2 (one-hot 0x04)
        bus(1'b1, A_CM + 9'd1, 2'd0, 64'h04, 2'd0, rd, er);
        chk("R7 moved to core2", 64'(irq), 64'h0100);
        bus(1'b0, A_ISR, 2'd3, 0, 2'd2, rd, er);
        chk("R7 core2 in-service", rd, 64'h2);
        bus(1'b0, A_ISR, 2'd3, 0, 2'd0, rd, er);
        chk("R7 core0 released", rd, 64'h0);
        bus(1'b1, A_CM + 9'd1, 2'd0, 64'h0C, 2'd0, rd, er);
        chk("R7 same core no change", 64'(irq), 64'h0100);
        bus(1'b0, A_ISR, 2'd3, 0, 2'd2, rd, er);
        chk("R7 same core in-service kept", rd, 64'h2);
        set_src(1, 1'b0);
        chk("R3 fall clears", 64'(irq), 64'h0);
        // R2: binary core mode, source 40 -> core 3, group 1 line 1
        bus(1'b1, A_ST, 2'd3, 64'h2, 2'd0, rd, er);
        bus(1'b1, A_CM + 9'd40, 2'd0, 64'h03, 2'd0, rd, er);
        bus(1'b1, A_EN, 2'd3, 64'h0000_0100_0000_0003, 2'd0, rd, er);
        set_src(40, 1'b1);
        chk("R2 binary core 3 line 1", 64'(irq), 64'h2000);
        set_src(40, 1'b0);
        chk("R3 fall core3", 64'(irq), 64'h0);
        // R9: status lock and feature mask
        bus(1'b1, A_ST, 2'd3, 64'h3, 2'd0, rd, er);
        chk("R9 write while disabled ok", 64'(er), 64'h0);
        bus(1'b1, A_ST, 2'd3, 64'h4, 2'd0, rd, er);
        chk("R9 locked write err", 64'(er), 64'h1);
        bus(1'b0, A_ST, 2'd3, 0, 2'd0, rd, er);
        chk("R9 locked value kept", rd, 64'h3);
        bus(1'b1, A_ST, 2'd3, 64'h0, 2'd0, rd, er);
        chk("R9 zero accepted", 64'(er), 64'h0);
        bus(1'b1, A_ST, 2'd3, 64'hFF, 2'd0, rd, er);
        bus(1'b0, A_ST, 2'd3, 0, 2'd0, rd, er);
        chk("R9 masked by feature", rd, 64'h7);
        bus(1'b1, A_ST, 2'd3, 64'h0, 2'd0, rd, er);
        // R1: binary line mode
        bus(1'b1, A_ST, 2'd3, 64'h4, 2'd0, rd, er);
        set_src(40, 1'b1);
        chk("R1 binary line 2", 64'(irq), 64'h0004);
        bus(1'b1, 9'h058, 2'd3, 64'h1, 2'd0, rd, er);
        set_src(192, 1'b1);
        chk("R1 binary out of range line 0", 64'(irq), 64'h0005);
        set_src(40, 1'b0);
        set_src(192, 1'b0);
        chk("R4 all low", 64'(irq), 64'h0);
        // R1/R2: one-hot out-of-range bytes
        bus(1'b1, A_ST, 2'd3, 64'h0, 2'd0, rd, er);
        bus(1'b1, A_CM + 9'd160, 2'd0, 64'h30, 2'd0, rd, er);
        bus(1'b0, A_CM + 9'd160, 2'd0, 0, 2'd0, rd, er);
        chk("R12 byte read of core map", rd, 64'h30);
        bus(1'b1, 9'h050, 2'd3, 64'h0000_0001_0000_0000, 2'd0, rd, er);
        set_src(160, 1'b1);
        chk("R1 R2 out of range one-hot to core0 line0", 64'(irq), 64'h0001);
        set_src(160, 1'b0);
        chk("R3 final fall", 64'(irq), 64'h0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule